// File: doc/BRIEF.md
# Secure Compare-Value Timer Channel

This block is one channel of a system timer. A free-running 64-bit count arrives from outside. The channel compares that count against a 64-bit absolute compare value that it stores. When the channel is enabled and the count has reached or passed the compare value, the timer condition holds. The condition shows up as a status bit in the control register. Unless it is masked, it also drives a registered level interrupt.

Software sees three registers: a control register (enable, mask, status), the absolute compare value, and a 32-bit signed "remaining time" view. Reading the view gives the distance from the count to the compare value. Writing it places the compare value a signed distance away from the current count, so the view behaves like a 32-bit down-counter.

Every register access first passes an access gate. The gate looks at the requester's privilege level and at the security configuration. It then allows the access, reports it as undefined, or requests a trap to the highest level.

The channel answers each request one cycle later, with an outcome, a syndrome and read data. Rejected accesses change no state.

Top module: `sct_timer_channel`

## Requirements
- R1: After reset the compare value is zero, the enable, mask and status bits read zero, `irq` is low, and `rsp_valid` is low.
- R2: The control register uses bit 0 for enable and bit 1 for mask, and both can be written. Bit 2 reads the timer condition and ignores writes. All other bits read zero.
- R3: With enable set, a read of the view (`req_sel`=2) returns the low 32 bits of (compare − count) in bits 31:0, with bits 63:32 zero.
- R4: A write to the view loads the compare value with count + the sign-extended `req_wdata[31:0]`. Bits 63:32 of the write data are ignored.
- R5: With enable set, the condition holds exactly when (count − compare), taken as a 64-bit two's-complement value, is not negative. It holds when compare equals count and does not hold when compare is count+1.
- R6: `irq` is the registered value of (condition AND NOT mask): it is high one cycle after both hold.
- R7: With enable clear, the status bit reads 0 and `irq` stays low, whatever the count and compare value are.
- R8: An access from level 0 or level 2 returns outcome undefined (`rsp_status`=1).
- R9: An access from level 3 is always allowed (`rsp_status`=0).
- R10: For an access from level 1, with level 3 implemented and the secure state active, the outcome depends on two controls. With secure level 2 enabled, it is undefined. Otherwise, with timer access control 0, it is a trap (`rsp_status`=2, `rsp_syndrome`=0x18). Otherwise it is allowed.
- R11: Every other access from level 1 (level 3 not implemented, or non-secure state) is undefined.
- R12: An access that is not allowed writes nothing and returns `rsp_rdata` zero. Its response arrives one cycle after the request, like that of any access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_i | input | 64 | Free-running system count |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 2 | 0 control, 1 compare value, 2 remaining-time view |
| req_wdata | input | 64 | Write data |
| req_el | input | 2 | Privilege level of the requester |
| has_el3 | input | 1 | Level 3 is implemented |
| ns_state | input | 1 | 1 = non-secure state |
| sec_el2_en | input | 1 | Secure level 2 enabled |
| sec_timer_acc | input | 1 | Level 1 may access the secure timer |
| rsp_valid | output | 1 | Response for last cycle's request |
| rsp_status | output | 2 | 0 allowed, 1 undefined, 2 trap |
| rsp_syndrome | output | 6 | Trap class code, 0x18 on trap, else 0 |
| rsp_rdata | output | 64 | Read data |
| irq | output | 1 | Level interrupt |

## Verification
Two events can fall in the same cycle: a write to the view, and the timer condition driving the interrupt. The bench sets up an enabled, unmasked channel whose condition holds, so `irq` is high. It then writes a positive remaining time to the view. The bench expects `irq` to still be high in the cycle after the write, because the registered interrupt was computed from the old compare value. In the following cycle `irq` must be low and the status bit must read 0. The exact-equality and one-past boundaries are also checked at the same count.

// File: rtl/sct_pkg.sv
// Shared types for the secure compare-value timer channel.
// Assumes: register selects and outcome codes are fixed by the brief.
package sct_pkg;
    typedef enum logic [1:0] {
        ACC_OK    = 2'd0,
        ACC_UNDEF = 2'd1,
        ACC_TRAP  = 2'd2
    } acc_res_t;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_CVAL = 2'd1,
        SEL_VIEW = 2'd2
    } reg_sel_t;

    localparam int CTRL_EN   = 0;
    localparam int CTRL_MASK = 1;
    localparam int CTRL_STAT = 2;
endpackage

// File: rtl/sct_access_gate.sv
// Access gate: classifies a register access by privilege level and
// security configuration into allowed, undefined or trap-to-level-3.
// Assumes: purely combinational; the caller registers the result.
module sct_access_gate
    import sct_pkg::*;
#(
    parameter int EC_W = 6,
    parameter logic [EC_W-1:0] TRAP_EC = 6'h18
) (
    input  logic [1:0]      el_i,
    input  logic            has_el3_i,
    input  logic            ns_i,
    input  logic            sec_el2_i,
    input  logic            st_i,
    output acc_res_t        res_o,
    output logic [EC_W-1:0] ec_o
);
    // Decision tree on privilege level, then on secure configuration.
    always_comb begin
        res_o = ACC_UNDEF;
        ec_o  = '0;
        unique case (el_i)
            2'd3: res_o = ACC_OK;
            2'd1: begin
                if (has_el3_i && !ns_i) begin
                    if (sec_el2_i) begin
                        res_o = ACC_UNDEF;
                    end else if (!st_i) begin
                        res_o = ACC_TRAP;
                        ec_o  = TRAP_EC;
                    end else begin
                        res_o = ACC_OK;
                    end
                end
            end
            default: res_o = ACC_UNDEF;
        endcase
    end
endmodule

// File: rtl/sct_cmp_core.sv
// Compare core: holds compare value and control bits, derives the
// timer condition and the remaining-time view, registers the interrupt.
// Assumes: wr_en_i is already qualified by the access gate.
module sct_cmp_core
    import sct_pkg::*;
#(
    parameter int CNT_W  = 64,
    parameter int VIEW_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             wr_en_i,
    input  reg_sel_t         sel_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] rdata_o,
    output logic             irq_o
);
    localparam int EXT_W = CNT_W - VIEW_W;

    logic [CNT_W-1:0] cval_q;
    logic             en_q;
    logic             mask_q;
    logic [CNT_W-1:0] elapsed;
    logic [CNT_W-1:0] remain;
    logic [CNT_W-1:0] view_sext;
    logic             cond;

    assign elapsed   = cnt_i - cval_q;
    assign remain    = cval_q - cnt_i;
    assign view_sext = {{EXT_W{wdata_i[VIEW_W-1]}}, wdata_i[VIEW_W-1:0]};
    assign cond      = en_q && !elapsed[CNT_W-1];

    // Register updates for compare value and control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cval_q <= '0;
            en_q   <= 1'b0;
            mask_q <= 1'b0;
        end else if (wr_en_i) begin
            case (sel_i)
                SEL_CTRL: begin
                    en_q   <= wdata_i[CTRL_EN];
                    mask_q <= wdata_i[CTRL_MASK];
                end
                SEL_CVAL: cval_q <= wdata_i;
                SEL_VIEW: cval_q <= cnt_i + view_sext;
                default: ;
            endcase
        end
    end

    // Registered level interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= cond && !mask_q;
    end

    // Read mux for the three registers.
    always_comb begin
        rdata_o = '0;
        case (sel_i)
            SEL_CTRL: begin
                rdata_o[CTRL_EN]   = en_q;
                rdata_o[CTRL_MASK] = mask_q;
                rdata_o[CTRL_STAT] = cond;
            end
            SEL_CVAL: rdata_o = cval_q;
            SEL_VIEW: if (en_q) rdata_o[VIEW_W-1:0] = remain[VIEW_W-1:0];
            default: ;
        endcase
    end

    a_r6_irq_needs_unmasked_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(en_q && !mask_q));
    a_r7_disabled_no_status: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !cond);
    a_r4_view_write_loads_cval: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && sel_i == SEL_VIEW) |=> cval_q == $past(cnt_i) + $past(view_sext));
    a_r12_no_write_keeps_cval: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(cval_q));
endmodule

// File: rtl/sct_timer_channel.sv
// Top of the secure timer channel: gates each access, forwards allowed
// accesses to the compare core and registers a one-cycle response.
// Assumes: one request per cycle; the count input is synchronous to clk.
module sct_timer_channel
    import sct_pkg::*;
#(
    parameter int CNT_W  = 64,
    parameter int VIEW_W = 32,
    parameter int EC_W   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [1:0]       req_sel,
    input  logic [CNT_W-1:0] req_wdata,
    input  logic [1:0]       req_el,
    input  logic             has_el3,
    input  logic             ns_state,
    input  logic             sec_el2_en,
    input  logic             sec_timer_acc,
    output logic             rsp_valid,
    output logic [1:0]       rsp_status,
    output logic [EC_W-1:0]  rsp_syndrome,
    output logic [CNT_W-1:0] rsp_rdata,
    output logic             irq
);
    localparam logic [EC_W-1:0] TRAP_EC = EC_W'(8'h18);

    acc_res_t         gate_res;
    logic [EC_W-1:0]  gate_ec;
    logic [CNT_W-1:0] core_rdata;
    logic             allowed;
    reg_sel_t         sel;

    assign sel     = reg_sel_t'(req_sel);
    assign allowed = req_valid && (gate_res == ACC_OK);

    sct_access_gate #(.EC_W(EC_W), .TRAP_EC(TRAP_EC)) u_gate (
        .el_i      (req_el),
        .has_el3_i (has_el3),
        .ns_i      (ns_state),
        .sec_el2_i (sec_el2_en),
        .st_i      (sec_timer_acc),
        .res_o     (gate_res),
        .ec_o      (gate_ec)
    );

    sct_cmp_core #(.CNT_W(CNT_W), .VIEW_W(VIEW_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_i   (cnt_i),
        .wr_en_i (allowed && req_write),
        .sel_i   (sel),
        .wdata_i (req_wdata),
        .rdata_o (core_rdata),
        .irq_o   (irq)
    );

    // Registered response: outcome, syndrome and read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_status   <= ACC_OK;
            rsp_syndrome <= '0;
            rsp_rdata    <= '0;
        end else begin
            rsp_valid    <= req_valid;
            rsp_status   <= req_valid ? gate_res : ACC_OK;
            rsp_syndrome <= req_valid ? gate_ec : '0;
            rsp_rdata    <= (allowed && !req_write) ? core_rdata : '0;
        end
    end

    a_r8_low_levels_undefined: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_el == 2'd0 || req_el == 2'd2)) |=> rsp_status == ACC_UNDEF);
    a_r9_top_level_allowed: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_el == 2'd3) |=> rsp_status == ACC_OK);
    a_r10_trap_carries_code: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_status == ACC_TRAP) |-> rsp_syndrome == TRAP_EC);
    a_r12_rejected_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_status != ACC_OK) |-> rsp_rdata == '0);
endmodule

// File: tb/test_sct_timer_channel.sv
// Directed bench for the secure timer channel; one task per scenario.
module test_sct_timer_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] cnt = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_sel = '0;
    logic [63:0] req_wdata = '0;
    logic [1:0]  req_el = 2'd3;
    logic        has_el3 = 1'b1;
    logic        ns_state = 1'b0;
    logic        sec_el2_en = 1'b0;
    logic        sec_timer_acc = 1'b1;
    logic        rsp_valid;
    logic [1:0]  rsp_status;
    logic [5:0]  rsp_syndrome;
    logic [63:0] rsp_rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;

    logic [1:0]  r_status;
    logic [5:0]  r_syn;
    logic [63:0] r_data;

    always #2 clk = ~clk;

    sct_timer_channel i_sct_timer_channel (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt),
        .req_valid(req_valid), .req_write(req_write), .req_sel(req_sel),
        .req_wdata(req_wdata), .req_el(req_el), .has_el3(has_el3),
        .ns_state(ns_state), .sec_el2_en(sec_el2_en), .sec_timer_acc(sec_timer_acc),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_syndrome(rsp_syndrome),
        .rsp_rdata(rsp_rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // One access: drive at negedge, sample response at next negedge.
    task automatic acc(input logic wr, input logic [1:0] sel, input logic [63:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_sel = sel; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        r_status = rsp_status; r_syn = rsp_syndrome; r_data = rsp_data_latch();
    endtask

    function automatic logic [63:0] rsp_data_latch();
        return rsp_rdata;
    endfunction

    task automatic set_priv(input logic [1:0] el, input logic e3, input logic ns,
                            input logic e2, input logic st);
        req_el = el; has_el3 = e3; ns_state = ns; sec_el2_en = e2; sec_timer_acc = st;
    endtask

    task automatic t_reset();
        chk("R1 irq", {63'd0, irq}, 64'd0);
        chk("R1 rsp_valid", {63'd0, rsp_valid}, 64'd0);
        acc(1'b0, 2'd1, '0);
        chk("R1 cval", r_data, 64'd0);
        acc(1'b0, 2'd0, '0);
        chk("R1 ctrl", r_data, 64'd0);
    endtask

    task automatic t_ctrl_bits();
        acc(1'b1, 2'd0, 64'hFFFF_FFFF_FFFF_FFFC);   // try status and high bits
        acc(1'b0, 2'd0, '0);
        chk("R2 ctrl writes ignored", r_data, 64'd0);
        cnt = 64'd10;
        acc(1'b1, 2'd1, 64'd50);
        acc(1'b1, 2'd0, 64'd3);                     // enable + mask
        acc(1'b0, 2'd0, '0);
        chk("R2 ctrl en+mask", r_data, 64'd3);
    endtask

    task automatic t_view_read();
        cnt = 64'h0000_0001_0000_0000;
        acc(1'b1, 2'd1, 64'h0000_0001_0000_1234);
        acc(1'b0, 2'd2, '0);
        chk("R3 view positive", r_data, 64'h0000_0000_0000_1234);
        cnt = 64'h0000_0001_0000_2000;
        acc(1'b0, 2'd2, '0);
        chk("R3 view past compare", r_data, {32'd0, 32'hFFFF_F234});
    endtask

    task automatic t_view_write();
        cnt = 64'h0000_0005_0000_0000;
        acc(1'b1, 2'd2, 64'hDEAD_BEEF_0000_0100);
        acc(1'b0, 2'd1, '0);
        chk("R4 view write positive", r_data, 64'h0000_0005_0000_0100);
        acc(1'b1, 2'd2, 64'h0000_0000_FFFF_FF00);   // -256
        acc(1'b0, 2'd1, '0);
        chk("R4 view write negative", r_data, 64'h0000_0004_FFFF_FF00);
    endtask

    task automatic t_condition();
        acc(1'b1, 2'd0, 64'd1);                     // enable, unmasked
        cnt = 64'd1000;
        acc(1'b1, 2'd1, 64'd1000);
        acc(1'b0, 2'd0, '0);
        chk("R5 equal holds", r_data, 64'd5);
        acc(1'b1, 2'd1, 64'd1001);
        acc(1'b0, 2'd0, '0);
        chk("R5 one-past not held", r_data, 64'd1);
        cnt = 64'h8000_0000_0000_0000;
        acc(1'b1, 2'd1, 64'd0);                     // difference sign bit set
        acc(1'b0, 2'd0, '0);
        chk("R5 sign of difference", r_data, 64'd1);
    endtask

    task automatic t_irq();
        cnt = 64'd2000;
        acc(1'b1, 2'd1, 64'd3000);
        @(negedge clk);
        chk("R6 irq low before", {63'd0, irq}, 64'd0);
        cnt = 64'd3000;
        @(negedge clk);
        chk("R6 irq high after one cycle", {63'd0, irq}, 64'd1);
        acc(1'b1, 2'd0, 64'd3);                     // mask it
        @(negedge clk);
        chk("R6 masked irq low", {63'd0, irq}, 64'd0);
    endtask

    task automatic t_same_cycle();
        acc(1'b1, 2'd0, 64'd1);
        cnt = 64'd4000;
        acc(1'b1, 2'd1, 64'd3990);
        @(negedge clk);
        chk("R6 irq before rewrite", {63'd0, irq}, 64'd1);
        acc(1'b1, 2'd2, 64'd100);
        chk("R6 irq uses old compare", {63'd0, irq}, 64'd1);
        @(negedge clk);
        chk("R4 irq drops after rewrite", {63'd0, irq}, 64'd0);
        acc(1'b0, 2'd0, '0);
        chk("R5 status after rewrite", r_data, 64'd1);
    endtask

    task automatic t_disabled();
        acc(1'b1, 2'd0, 64'd0);
        cnt = 64'd9000;
        acc(1'b1, 2'd1, 64'd10);
        @(negedge clk);
        @(negedge clk);
        chk("R7 irq stays low", {63'd0, irq}, 64'd0);
        acc(1'b0, 2'd0, '0);
        chk("R7 status zero", r_data, 64'd0);
    endtask

    task automatic t_gate();
        set_priv(2'd0, 1, 0, 0, 1); acc(1'b0, 2'd0, '0);
        chk("R8 level0", {62'd0, r_status}, 64'd1);
        set_priv(2'd2, 1, 0, 0, 1); acc(1'b0, 2'd0, '0);
        chk("R8 level2", {62'd0, r_status}, 64'd1);
        set_priv(2'd3, 0, 1, 1, 0); acc(1'b0, 2'd0, '0);
        chk("R9 level3", {62'd0, r_status}, 64'd0);
        set_priv(2'd1, 1, 0, 1, 1); acc(1'b0, 2'd0, '0);
        chk("R10 secure el2 undef", {62'd0, r_status}, 64'd1);
        set_priv(2'd1, 1, 0, 0, 0); acc(1'b0, 2'd0, '0);
        chk("R10 trap status", {62'd0, r_status}, 64'd2);
        chk("R10 trap code", {58'd0, r_syn}, 64'h18);
        set_priv(2'd1, 1, 0, 0, 1); acc(1'b0, 2'd0, '0);
        chk("R10 allowed", {62'd0, r_status}, 64'd0);
        set_priv(2'd1, 1, 1, 0, 1); acc(1'b0, 2'd0, '0);
        chk("R11 non-secure undef", {62'd0, r_status}, 64'd1);
        set_priv(2'd1, 0, 0, 0, 1); acc(1'b0, 2'd0, '0);
        chk("R11 no level3 undef", {62'd0, r_status}, 64'd1);
        set_priv(2'd3, 1, 0, 0, 1);
    endtask

    task automatic t_blocked();
        acc(1'b1, 2'd1, 64'h1111);
        set_priv(2'd1, 1, 0, 0, 0);
        acc(1'b1, 2'd1, 64'h2222);
        chk("R12 trapped write status", {62'd0, r_status}, 64'd2);
        acc(1'b0, 2'd1, '0);
        chk("R12 trapped read data zero", r_data, 64'd0);
        set_priv(2'd0, 1, 0, 0, 1);
        acc(1'b1, 2'd2, 64'h5);
        set_priv(2'd3, 1, 0, 0, 1);
        acc(1'b0, 2'd1, '0);
        chk("R12 compare unchanged", r_data, 64'h1111);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl_bits();
        t_view_read();
        t_view_write();
        t_condition();
        t_irq();
        t_same_cycle();
        t_disabled();
        t_gate();
        t_blocked();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule